// File: doc/BRIEF.md
# Single-Phase Bridge Commutation Controller

This block sequences the four gate enables of an H-bridge that drives the winding of a single-phase brushless fan. A filtered Hall bit chooses which diagonal of the bridge conducts. A speed enable gates the source switch on and off. A current-trip pulse forces a fixed recirculation window. An early-decay request moves the bridge into slow decay ahead of the coming Hall edge. Three fault flags shut the whole bridge off. The analog parts (Hall comparator, sense comparator, PWM ramp, supply and temperature monitors) sit outside and reach the block only as single digital bits in the block's clock domain.

Each bridge leg has its own dead-time sequencer, so the two switches of one leg are never on together. Whenever the source high-side switch is not being driven, both low-side switches conduct. This short-circuits the winding for slow decay, which gives synchronous rectification through the switch instead of through the body diode. The filtered Hall state is also brought out as the speed output. All timing windows are parameters counted in clock cycles. The defaults suit a 10 MHz clock: a 2 us filter, a 1 us dead time and a 50 us recirculation window.

Top module: `fan_bridge_ctrl`

## Requirements
- R1: With filtered Hall state 1 and the source driven, `gate_ha` and `gate_lb` are on. With state 0, `gate_hb` and `gate_la` are on. A high-side switch is never on unless the Hall state of the previous cycle selects it.
- R2: Within one leg, a switch turns on only after the other switch of that leg has been off for at least DEAD_CYC cycles. A swap from one switch to the other keeps the leg fully off for exactly DEAD_CYC cycles.
- R3: A trip pulse seen while the source is enabled clears the source enable. The active high-side switch goes off on the second clock edge after the trip is sampled.
- R4: Whenever the source is not driven (speed enable low, recirculation, early decay or commutation blank), both low-side switches are on once the dead time has run, with both high-side switches off.
- R5: After a trip, the source stays disabled for exactly REC_CYC cycles. A trip that arrives during that window has no effect on its length.
- R6: A Hall input level that differs from the accepted state is taken over only after FILT_CYC consecutive cycles. Shorter pulses are rejected. `fg` equals the accepted Hall state.
- R7: If any of the three fault flags is sampled high, all four gate enables are off from the next clock edge until the flags clear. Restart then respects R2.
- R8: A sampled early-decay request holds the bridge in slow decay until the next accepted Hall edge. A request on the same edge as the acceptance is dropped.
- R9: During reset and after it, all gate enables and `fg` are 0. No switch turns on until DEAD_CYC cycles after reset is released.
- R10: Each accepted Hall edge starts a blank of DEAD_CYC cycles during which the source is not driven. Both high-side switches are therefore off on the edge that follows the change of `fg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall_in | input | 1 | Hall comparator bit, synchronous to clk |
| speed_on | input | 1 | Speed PWM enable, 1 = drive source switch |
| trip_in | input | 1 | Peak-current trip, sampled level |
| early_decay | input | 1 | Request slow decay ahead of the Hall edge |
| flt_temp | input | 1 | Over-temperature fault |
| flt_vbb | input | 1 | Low supply fault |
| flt_vcp | input | 1 | Low charge-pump fault |
| gate_ha | output | 1 | High-side enable, leg A |
| gate_la | output | 1 | Low-side enable, leg A |
| gate_hb | output | 1 | High-side enable, leg B |
| gate_lb | output | 1 | Low-side enable, leg B |
| fg | output | 1 | Speed output, filtered Hall state |

## Verification
The assertions assume that every input is already synchronous to `clk` and stable around the rising edge. They also assume that the Hall bit, trip and fault flags are plain sampled levels. No metastability or sub-cycle pulse is modelled. The stimulus changes inputs only on the falling edge and uses short parameter values (filter 4, dead time 3, recirculation 8), so that every window can be reached and passed in a few cycles. Trip and early-decay pulses last one cycle. Hall glitches stay one cycle shorter than the filter. A second trip is placed inside the recirculation window to show that it has no effect.

// File: rtl/fanb_pkg.sv
package fanb_pkg;
   // requested / current state of one bridge leg
   typedef enum logic [1:0] {
      LEG_OFF = 2'd0,
      LEG_HI  = 2'd1,
      LEG_LO  = 2'd2
   } leg_e;
endpackage

// File: rtl/fanb_hall_filter.sv
module fanb_hall_filter #(
   parameter int unsigned FILT_CYC = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hall_in,
   output logic hall_q,
   output logic acc_q
);
   generate
      if (FILT_CYC < 1) begin : g_bad_filt
         $error("fanb_hall_filter: FILT_CYC must be at least 1");
      end

      if (FILT_CYC == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hall_q <= 1'b0;
               acc_q  <= 1'b0;
            end else begin
               acc_q  <= (hall_in != hall_q);
               hall_q <= hall_in;
            end
         end
      end else begin : g_count
         localparam int unsigned CW = $clog2(FILT_CYC);
         localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);
         logic [CW-1:0] run_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hall_q <= 1'b0;
               acc_q  <= 1'b0;
               run_q  <= '0;
            end else begin
               acc_q <= 1'b0;
               if (hall_in == hall_q) begin
                  run_q <= '0;
               end else if (run_q == LAST) begin
                  hall_q <= hall_in;
                  acc_q  <= 1'b1;
                  run_q  <= '0;
               end else begin
                  run_q <= run_q + 1'b1;
               end
            end
         end
      end
   endgenerate

   // R6: the accepted state only ever moves to the level just sampled
   assert_filter_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(hall_q) |-> (hall_q == $past(hall_in)));
endmodule

// File: rtl/fanb_recirc_timer.sv
module fanb_recirc_timer #(
   parameter int unsigned REC_CYC = 500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trip_in,
   output logic src_en
);
   localparam int unsigned CW = $clog2(REC_CYC + 1);
   localparam logic [CW-1:0] LOAD = CW'(REC_CYC - 1);

   generate
      if (REC_CYC < 1) begin : g_bad_rec
         $error("fanb_recirc_timer: REC_CYC must be at least 1");
      end
   endgenerate

   logic [CW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_en <= 1'b1;
         left_q <= '0;
      end else if (src_en) begin
         if (trip_in) begin
            src_en <= 1'b0;
            left_q <= LOAD;
         end
      end else if (left_q != '0) begin
         left_q <= left_q - 1'b1;
      end else begin
         src_en <= 1'b1;
      end
   end

   // R3: a trip while enabled clears the source latch on that edge
   assert_trip_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (trip_in && src_en) |=> !src_en);
endmodule

// File: rtl/fanb_leg_dt.sv
module fanb_leg_dt
   import fanb_pkg::*;
#(
   parameter int unsigned DEAD_CYC = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  leg_e req,
   output logic hi,
   output logic lo
);
   localparam int unsigned CW = $clog2(DEAD_CYC + 1);
   localparam logic [CW-1:0] LOAD = CW'(DEAD_CYC - 1);
   localparam logic [CW-1:0] FULL = CW'(DEAD_CYC);

   generate
      if (DEAD_CYC < 1) begin : g_bad_dead
         $error("fanb_leg_dt: DEAD_CYC must be at least 1");
      end
   endgenerate

   leg_e          cur_q;
   logic [CW-1:0] gap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q <= LEG_OFF;
         gap_q <= LOAD;
      end else if (cur_q != LEG_OFF && req != cur_q) begin
         cur_q <= LEG_OFF;
         gap_q <= LOAD;
      end else if (cur_q == LEG_OFF) begin
         if (gap_q != '0) gap_q <= gap_q - 1'b1;
         else if (req != LEG_OFF) cur_q <= req;
      end
   end

   assign hi = (cur_q == LEG_HI);
   assign lo = (cur_q == LEG_LO);

   // checker: cycles each switch has been off, saturating at DEAD_CYC
   logic [CW-1:0] hi_off_q, lo_off_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_off_q <= '0;
         lo_off_q <= '0;
      end else begin
         hi_off_q <= hi ? '0 : ((hi_off_q == FULL) ? FULL : hi_off_q + 1'b1);
         lo_off_q <= lo ? '0 : ((lo_off_q == FULL) ? FULL : lo_off_q + 1'b1);
      end
   end

   assert_hi_dead_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hi) |-> (lo_off_q >= FULL));
   assert_lo_dead_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lo) |-> (hi_off_q >= FULL));
endmodule

// File: rtl/fan_bridge_ctrl.sv
module fan_bridge_ctrl
   import fanb_pkg::*;
#(
   parameter int unsigned FILT_CYC = 20,
   parameter int unsigned DEAD_CYC = 10,
   parameter int unsigned REC_CYC  = 500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hall_in,
   input  logic speed_on,
   input  logic trip_in,
   input  logic early_decay,
   input  logic flt_temp,
   input  logic flt_vbb,
   input  logic flt_vcp,
   output logic gate_ha,
   output logic gate_la,
   output logic gate_hb,
   output logic gate_lb,
   output logic fg
);
   localparam int unsigned NLEG = 2;
   localparam int unsigned BW   = $clog2(DEAD_CYC + 1);
   localparam logic [BW-1:0] BLOAD = BW'(DEAD_CYC - 1);

   logic hall_f, hall_acc, src_en;
   logic early_q;
   logic [BW-1:0] blank_q;
   logic blank, drive, fault_any;
   logic [NLEG-1:0] leg_hi, leg_lo;

   fanb_hall_filter #(.FILT_CYC(FILT_CYC)) u_filt (
      .clk(clk), .rst_n(rst_n), .hall_in(hall_in),
      .hall_q(hall_f), .acc_q(hall_acc)
   );

   fanb_recirc_timer #(.REC_CYC(REC_CYC)) u_recirc (
      .clk(clk), .rst_n(rst_n), .trip_in(trip_in), .src_en(src_en)
   );

   // commutation blank and early slow-decay latch
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blank_q <= '0;
         early_q <= 1'b0;
      end else begin
         if (hall_acc) blank_q <= BLOAD;
         else if (blank_q != '0) blank_q <= blank_q - 1'b1;

         if (hall_acc) early_q <= 1'b0;
         else if (early_decay) early_q <= 1'b1;
      end
   end

   assign fault_any = flt_temp | flt_vbb | flt_vcp;
   assign blank     = hall_acc | (blank_q != '0);
   assign drive     = speed_on & src_en & ~early_q & ~blank;

   genvar i;
   generate
      for (i = 0; i < NLEG; i++) begin : g_leg
         // leg 0 (A) sources for Hall state 1, leg 1 (B) for state 0
         localparam bit SRC_STATE = (i == 0);
         leg_e req;

         always_comb begin
            if (fault_any)                             req = LEG_OFF;
            else if (drive && (hall_f == SRC_STATE))   req = LEG_HI;
            else                                       req = LEG_LO;
         end

         fanb_leg_dt #(.DEAD_CYC(DEAD_CYC)) u_leg (
            .clk(clk), .rst_n(rst_n), .req(req),
            .hi(leg_hi[i]), .lo(leg_lo[i])
         );
      end
   endgenerate

   assign gate_ha = leg_hi[0];
   assign gate_la = leg_lo[0];
   assign gate_hb = leg_hi[1];
   assign gate_lb = leg_lo[1];
   assign fg      = hall_f;

   // R7: any fault empties the bridge on the next edge
   assert_fault_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fault_any |=> !(gate_ha || gate_la || gate_hb || gate_lb));

   // R1: high-side choice agrees with the Hall state seen a cycle earlier
   assert_diag_a_R1: assert property (@(posedge clk) disable iff (!rst_n)
      gate_ha |-> ($past(fg) && !gate_hb));
   assert_diag_b_R1: assert property (@(posedge clk) disable iff (!rst_n)
      gate_hb |-> (!$past(fg) && !gate_ha));

   // R10: the edge after an fg change has both high-side switches off
   assert_comm_blank_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(fg) |=> !(gate_ha || gate_hb));
endmodule

// File: tb/tb_fan_bridge_ctrl.sv
module tb_fan_bridge_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hall_in = 0, speed_on = 0, trip_in = 0, early_decay = 0;
   logic flt_temp = 0, flt_vbb = 0, flt_vcp = 0;
   logic gate_ha, gate_la, gate_hb, gate_lb, fg;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;

   typedef struct {
      int         at;
      logic [4:0] val;
      string      tag;
   } exp_t;
   exp_t sb[$];

   always #2 clk = ~clk;

   fan_bridge_ctrl #(.FILT_CYC(4), .DEAD_CYC(3), .REC_CYC(8)) dut (
      .clk(clk), .rst_n(rst_n), .hall_in(hall_in), .speed_on(speed_on),
      .trip_in(trip_in), .early_decay(early_decay), .flt_temp(flt_temp),
      .flt_vbb(flt_vbb), .flt_vcp(flt_vcp), .gate_ha(gate_ha),
      .gate_la(gate_la), .gate_hb(gate_hb), .gate_lb(gate_lb), .fg(fg)
   );

   // observed vector: {ha, la, hb, lb, fg}
   wire [4:0] obs = {gate_ha, gate_la, gate_hb, gate_lb, fg};

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   // monitor: pop and compare expectations due in this cycle
   always @(negedge clk) begin
      if (rst_n) begin
         while (sb.size() > 0 && sb[0].at <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (e.at != cyc || obs !== e.val) begin
               errors++;
               $display("FAIL %s cycle %0d (due %0d): got %b expected %b",
                        e.tag, cyc, e.at, obs, e.val);
            end
         end
      end
   end

   task automatic expect_in(input int k, input logic [4:0] v, input string tag);
      exp_t e;
      e.at = cyc + k; e.val = v; e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      step(3);
      checks++;
      if (obs !== 5'b00000) begin
         errors++;
         $display("FAIL R9 reset state: got %b expected %b", obs, 5'b00000);
      end
      rst_n = 1'b1;                                   // cycle 0
      expect_in(1, 5'b00000, "R9 no enable before dead time");
      expect_in(3, 5'b01010, "R9 R4 both low sides after power-up");
      step(4);                                        // cycle 4
      speed_on = 1'b1;
      expect_in(1, 5'b01000, "R2 leg B off during swap");
      expect_in(3, 5'b01000, "R2 leg B still off");
      expect_in(4, 5'b01100, "R1 Hall 0 diagonal");
      step(6);                                        // cycle 10
      hall_in = 1'b1;
      step(3);                                        // cycle 13
      hall_in = 1'b0;
      expect_in(2, 5'b01100, "R6 short Hall pulse rejected");
      step(3);                                        // cycle 16
      hall_in = 1'b1;
      expect_in(4, 5'b01101, "R6 fg after filter time");
      expect_in(5, 5'b01001, "R10 old high side off");
      expect_in(8, 5'b00011, "R10 both high sides off");
      expect_in(10, 5'b00011, "R10 dead interval holds");
      expect_in(11, 5'b10011, "R1 Hall 1 diagonal");
      step(12);                                       // cycle 28
      trip_in = 1'b1;
      expect_in(2, 5'b00011, "R3 trip turns source off");
      expect_in(5, 5'b01011, "R4 sync rectification in recirculation");
      expect_in(8, 5'b01011, "R5 window still running");
      expect_in(10, 5'b00011, "R5 window ends on time");
      expect_in(13, 5'b10011, "R5 source back after retrigger ignored");
      step(1); trip_in = 1'b0;                        // cycle 29
      step(2); trip_in = 1'b1;                        // cycle 31
      step(1); trip_in = 1'b0;                        // cycle 32
      step(10);                                       // cycle 42
      speed_on = 1'b0;
      expect_in(1, 5'b00011, "R4 source off at speed gap");
      expect_in(4, 5'b01011, "R4 both low sides in speed gap");
      step(5);                                        // cycle 47
      speed_on = 1'b1;
      expect_in(1, 5'b00011, "R2 low side off before high side");
      expect_in(4, 5'b10011, "R2 high side after dead time");
      step(5);                                        // cycle 52
      early_decay = 1'b1;
      expect_in(2, 5'b00011, "R8 early decay stops source");
      expect_in(5, 5'b01011, "R8 slow decay");
      expect_in(10, 5'b01011, "R8 held until Hall edge");
      step(1); early_decay = 1'b0;                    // cycle 53
      step(9);                                        // cycle 62
      hall_in = 1'b0;
      expect_in(4, 5'b01010, "R6 fg follows accepted state");
      expect_in(8, 5'b01000, "R10 swap after blank");
      expect_in(11, 5'b01100, "R8 drive resumes after edge");
      step(14);                                       // cycle 76
      flt_temp = 1'b1;
      expect_in(1, 5'b00000, "R7 temperature fault clears gates");
      expect_in(4, 5'b00000, "R7 gates stay off in fault");
      step(4); flt_temp = 1'b0;                       // cycle 80
      expect_in(1, 5'b01100, "R7 restart after fault");
      step(4); flt_vcp = 1'b1;                        // cycle 84
      expect_in(1, 5'b00000, "R7 charge-pump fault clears gates");
      step(1); flt_vcp = 1'b0;                        // cycle 85
      expect_in(2, 5'b00000, "R2 dead time after short fault");
      expect_in(3, 5'b01100, "R2 restart after dead time");
      step(5); flt_vbb = 1'b1;                        // cycle 90
      expect_in(1, 5'b00000, "R7 supply fault clears gates");
      step(2); flt_vbb = 1'b0;
      while (sb.size() > 0) step(1);
      step(2);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got hung run expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule